// File: doc/BRIEF.md
# PCM Serial Audio Port (Clock and Frame Master)

This block drives a short-frame serial audio link as its clock and frame master. It derives a bit clock and a once-per-frame sync pulse from one of two sources: the block's own clock, used on every cycle, or an audio-rate enable pulse supplied from outside. Each frame carries one 16-bit transmit word out on the serial data line and collects one 16-bit receive word from the serial input. Both words are sent most significant bit first.

Configuration arrives on plain input pins. These set the source select, a half-period divider for the bit clock, a frame-length divider, the MSB position for each direction, and the enables. Divider and format settings are captured only while the port is stopped, so a running link never sees a mid-frame change. Transmit words are taken from a producer through a valid/ready handshake once per frame. Receive words are offered with a valid flag that stays up until the consumer accepts them.

Top module: `pcm_master_port`

## Requirements
- R1: The bit clock `pcm_sclk` has a period of 2×(`cfg_sclk_div`+1) source ticks. A source tick is every clock cycle when `cfg_src_bus`=1, and each cycle with `aud_tick`=1 when `cfg_src_bus`=0.
- R2: A frame lasts `cfg_sync_div`+1 bit periods. `pcm_fsync` goes high for exactly the first bit period of each frame and changes only when `pcm_sclk` rises.
- R3: `pcm_sclk` idles low. `pcm_sdo` and `pcm_fsync` change when `pcm_sclk` rises, and `pcm_sdi` is captured when `pcm_sclk` falls.
- R4: The transmit word goes out MSB first over 16 consecutive bits. With `cfg_tx_late`=0 the MSB is in bit 0 of the frame (the sync bit); with `cfg_tx_late`=1 it is in bit 1. All other bits of the frame are 0.
- R5: The receive word is assembled MSB first from 16 bits, starting at bit 0 when `cfg_rx_late`=0 and at bit 1 when `cfg_rx_late`=1. It appears on `rx_data` with `rx_valid`=1, and `rx_valid` stays high until a cycle with `rx_ready`=1.
- R6: While transmit is running, `tx_ready` pulses for one cycle per frame, in the cycle before the MSB bit starts. The word on `tx_data` is taken in that cycle if `tx_valid`=1.
- R7: If `tx_valid`=0 in the `tx_ready` cycle, the frame's transmit bits are all zero and `tx_starve` pulses for that one cycle.
- R8: Dropping `cfg_en` has no effect while `cfg_tx_en` or `cfg_rx_en` is high. The port stops once all three are low.
- R9: The bit clock toggles only when the port runs, `cfg_sclk_en`=1, and either continuous clocking (`cfg_cont`=1) is chosen or a direction is enabled. Otherwise it rests low.
- R10: Changes on `cfg_sclk_div`, `cfg_sync_div`, `cfg_cont`, `cfg_src_bus` and the late bits have no effect while the port runs.
- R11: After reset `pcm_sclk`, `pcm_fsync`, `pcm_sdo`, `tx_ready`, `tx_starve` and `rx_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Global port enable |
| cfg_tx_en | input | 1 | Transmit direction enable |
| cfg_rx_en | input | 1 | Receive direction enable |
| cfg_sclk_en | input | 1 | Bit clock gate |
| cfg_cont | input | 1 | Keep clock running with both directions off |
| cfg_src_bus | input | 1 | 1: tick every cycle, 0: tick on aud_tick |
| cfg_sclk_div | input | DIV_W | Bit clock half-period divider |
| cfg_sync_div | input | DIV_W | Frame length minus one, in bits |
| cfg_tx_late | input | 1 | Transmit MSB one bit after sync |
| cfg_rx_late | input | 1 | Receive MSB one bit after sync |
| aud_tick | input | 1 | Audio-rate source enable pulse |
| tx_data | input | SAMPLE_W | Transmit word |
| tx_valid | input | 1 | Transmit word present |
| tx_ready | output | 1 | Transmit word taken this cycle |
| tx_starve | output | 1 | Transmit underrun pulse |
| rx_data | output | SAMPLE_W | Received word |
| rx_valid | output | 1 | Received word present |
| rx_ready | input | 1 | Received word accepted |
| pcm_sclk | output | 1 | Serial bit clock |
| pcm_fsync | output | 1 | Frame sync |
| pcm_sdo | output | 1 | Serial data out |
| pcm_sdi | input | 1 | Serial data in |

## Verification
The bench uses the default widths: 16-bit samples and 9-bit dividers. Because the dividers are pins, it programs a half-period of two cycles and a 32-bit frame. This keeps a full frame at 128 cycles, so many frames fit in a short run. The serial output is looped back to the input, and the bench crosses both late-MSB settings. The mismatched pairs show up as a one-bit shift of the received word, which separates the transmit and receive timing. A slow audio-tick source and a divider change during a run check the clocking path and the capture of settings while stopped.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

    localparam int SAMPLE_W_DEF = 16;
    localparam int DIV_W_DEF    = 9;
    localparam int SYNC_RST     = 127;

    // format flags held while the port runs
    typedef struct packed {
        logic src_bus;
        logic cont;
        logic tx_late;
        logic rx_late;
    } fmt_t;

endpackage

// File: rtl/pcmp_clkgen.sv
module pcmp_clkgen #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             tick,
    input  logic [DIV_W-1:0] sclk_div,
    input  logic [DIV_W-1:0] sync_div,
    output logic             sclk,
    output logic             fsync,
    output logic             go_hi,
    output logic             go_lo,
    output logic [DIV_W-1:0] nxt_pos,
    output logic [DIV_W-1:0] cur_pos
);
    logic [DIV_W-1:0] hcnt;
    logic [DIV_W-1:0] pos;
    logic             phase;
    logic             fresh;
    logic             fs_q;
    logic             at_div;

    assign at_div  = active & tick & (hcnt == sclk_div);
    assign go_hi   = at_div & ~phase;
    assign go_lo   = at_div & phase;
    assign nxt_pos = (fresh || pos == sync_div) ? '0 : pos + DIV_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            hcnt  <= '0;
            pos   <= '0;
            phase <= 1'b0;
            fresh <= 1'b1;
            fs_q  <= 1'b0;
        end else if (tick) begin
            if (hcnt == sclk_div) begin
                hcnt  <= '0;
                phase <= ~phase;
                if (!phase) begin
                    pos   <= nxt_pos;
                    fresh <= 1'b0;
                    fs_q  <= (nxt_pos == '0);
                end
            end else begin
                hcnt <= hcnt + DIV_W'(1);
            end
        end
    end

    assign sclk    = phase;
    assign fsync   = fs_q;
    assign cur_pos = pos;
endmodule

// File: rtl/pcmp_tx.sv
module pcmp_tx #(
    parameter int SAMPLE_W = 16,
    parameter int DIV_W    = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                late,
    input  logic                go_hi,
    input  logic [DIV_W-1:0]    nxt_pos,
    input  logic [SAMPLE_W-1:0] tx_data,
    input  logic                tx_valid,
    output logic                sdo,
    output logic                tx_ready,
    output logic                tx_starve
);
    logic [SAMPLE_W-1:0] sh;
    logic [SAMPLE_W-1:0] word;
    logic                load;

    assign load      = enable & go_hi & (nxt_pos == {{(DIV_W-1){1'b0}}, late});
    assign tx_ready  = load;
    assign tx_starve = load & ~tx_valid;
    assign word      = tx_valid ? tx_data : '0;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            sh  <= '0;
            sdo <= 1'b0;
        end else if (go_hi) begin
            if (load) begin
                sdo <= word[SAMPLE_W-1];
                sh  <= word << 1;
            end else begin
                sdo <= sh[SAMPLE_W-1];
                sh  <= sh << 1;
            end
        end
    end
endmodule

// File: rtl/pcmp_rx.sv
module pcmp_rx #(
    parameter int SAMPLE_W = 16,
    parameter int DIV_W    = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                late,
    input  logic                go_lo,
    input  logic [DIV_W-1:0]    cur_pos,
    input  logic                sdi,
    input  logic                rx_ready,
    output logic [SAMPLE_W-1:0] rx_data,
    output logic                rx_valid
);
    localparam logic [DIV_W-1:0] LAST = DIV_W'(SAMPLE_W - 1);

    logic [DIV_W-1:0]    late_x;
    logic [DIV_W-1:0]    rel;
    logic                in_slot;
    logic [SAMPLE_W-1:0] sh;
    logic [SAMPLE_W-1:0] sh_nxt;

    assign late_x  = {{(DIV_W-1){1'b0}}, late};
    assign rel     = cur_pos - late_x;
    assign in_slot = (cur_pos >= late_x) && (rel <= LAST);
    assign sh_nxt  = {sh[SAMPLE_W-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            if (rx_valid && rx_ready) rx_valid <= 1'b0;
            if (enable && go_lo && in_slot) begin
                sh <= sh_nxt;
                if (rel == LAST) begin
                    rx_data  <= sh_nxt;
                    rx_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_master_port.sv
module pcm_master_port
    import pcmp_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int DIV_W    = DIV_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_en,
    input  logic                cfg_tx_en,
    input  logic                cfg_rx_en,
    input  logic                cfg_sclk_en,
    input  logic                cfg_cont,
    input  logic                cfg_src_bus,
    input  logic [DIV_W-1:0]    cfg_sclk_div,
    input  logic [DIV_W-1:0]    cfg_sync_div,
    input  logic                cfg_tx_late,
    input  logic                cfg_rx_late,
    input  logic                aud_tick,
    input  logic [SAMPLE_W-1:0] tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    output logic                tx_starve,
    output logic [SAMPLE_W-1:0] rx_data,
    output logic                rx_valid,
    input  logic                rx_ready,
    output logic                pcm_sclk,
    output logic                pcm_fsync,
    output logic                pcm_sdo,
    input  logic                pcm_sdi
);
    logic             run_q;
    fmt_t             fmt_q;
    logic [DIV_W-1:0] sdiv_q;
    logic [DIV_W-1:0] fdiv_q;
    logic             tick;
    logic             active;
    logic             go_hi;
    logic             go_lo;
    logic [DIV_W-1:0] nxt_pos;
    logic [DIV_W-1:0] cur_pos;

    // run stays up while any direction is still on; settings follow pins only when stopped
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            fmt_q  <= '0;
            sdiv_q <= '0;
            fdiv_q <= DIV_W'(SYNC_RST);
        end else begin
            run_q <= cfg_en | (run_q & (cfg_tx_en | cfg_rx_en));
            if (!run_q) begin
                fmt_q  <= '{src_bus: cfg_src_bus, cont: cfg_cont,
                           tx_late: cfg_tx_late, rx_late: cfg_rx_late};
                sdiv_q <= cfg_sclk_div;
                fdiv_q <= cfg_sync_div;
            end
        end
    end

    assign tick   = fmt_q.src_bus | aud_tick;
    assign active = run_q & cfg_sclk_en & (fmt_q.cont | cfg_tx_en | cfg_rx_en);

    pcmp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .tick     (tick),
        .sclk_div (sdiv_q),
        .sync_div (fdiv_q),
        .sclk     (pcm_sclk),
        .fsync    (pcm_fsync),
        .go_hi    (go_hi),
        .go_lo    (go_lo),
        .nxt_pos  (nxt_pos),
        .cur_pos  (cur_pos)
    );

    pcmp_tx #(.SAMPLE_W(SAMPLE_W), .DIV_W(DIV_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .enable    (active & cfg_tx_en),
        .late      (fmt_q.tx_late),
        .go_hi     (go_hi),
        .nxt_pos   (nxt_pos),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .sdo       (pcm_sdo),
        .tx_ready  (tx_ready),
        .tx_starve (tx_starve)
    );

    pcmp_rx #(.SAMPLE_W(SAMPLE_W), .DIV_W(DIV_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .enable   (active & cfg_rx_en),
        .late     (fmt_q.rx_late),
        .go_lo    (go_lo),
        .cur_pos  (cur_pos),
        .sdi      (pcm_sdi),
        .rx_ready (rx_ready),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );
endmodule

// File: rtl/pcm_master_port_chk.sv
module pcm_master_port_chk (
    input logic clk,
    input logic rst,
    input logic cfg_en,
    input logic cfg_tx_en,
    input logic cfg_rx_en,
    input logic cfg_sclk_en,
    input logic pcm_sclk,
    input logic pcm_fsync,
    input logic pcm_sdo,
    input logic tx_ready,
    input logic tx_valid,
    input logic tx_starve,
    input logic rx_valid,
    input logic rx_ready
);
    AST_FSYNC_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(pcm_fsync) |-> $rose(pcm_sclk)); // R2

    AST_SDO_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(pcm_sdo) |-> $rose(pcm_sclk)); // R3

    AST_READY_BEFORE_RISE: assert property (@(posedge clk) disable iff (rst)
        tx_ready |=> $rose(pcm_sclk)); // R6

    AST_STARVE_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_starve |=> !tx_starve); // R7

    AST_STARVE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        tx_starve |-> !tx_valid); // R7

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !rx_ready |=> rx_valid); // R5

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
        !cfg_sclk_en |=> !pcm_sclk); // R9

    AST_IDLE_STOP: assert property (@(posedge clk) disable iff (rst)
        !cfg_en && !cfg_tx_en && !cfg_rx_en |=> ##1 !pcm_sclk); // R8
endmodule

bind pcm_master_port pcm_master_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_en      (cfg_en),
    .cfg_tx_en   (cfg_tx_en),
    .cfg_rx_en   (cfg_rx_en),
    .cfg_sclk_en (cfg_sclk_en),
    .pcm_sclk    (pcm_sclk),
    .pcm_fsync   (pcm_fsync),
    .pcm_sdo     (pcm_sdo),
    .tx_ready    (tx_ready),
    .tx_valid    (tx_valid),
    .tx_starve   (tx_starve),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready)
);

// File: tb/pcm_master_port_bench.sv
`timescale 1ns/1ps
module pcm_master_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_en = 0, cfg_tx_en = 0, cfg_rx_en = 0, cfg_sclk_en = 1;
    logic        cfg_cont = 0, cfg_src_bus = 1, cfg_tx_late = 0, cfg_rx_late = 0;
    logic [8:0]  cfg_sclk_div = 9'd1, cfg_sync_div = 9'd31;
    logic        aud_tick = 0;
    logic [15:0] tx_data = '0;
    logic        tx_valid = 0, rx_ready = 0;
    logic        tx_ready, tx_starve, rx_valid;
    logic [15:0] rx_data;
    logic        pcm_sclk, pcm_fsync, pcm_sdo, pcm_sdi;
    int          n_run = 0, n_fail = 0, cyc = 0;
    logic        done = 0;

    always #2.5 clk = ~clk;

    assign pcm_sdi = pcm_sdo;

    pcm_master_port u_pcm_master_port (.*);

    // {tx_late, rx_late}, word sent, word expected back
    localparam logic [1:0]  V_LATE [5] = '{2'b00, 2'b11, 2'b10, 2'b01, 2'b00};
    localparam logic [15:0] V_WORD [5] = '{16'hA5C3, 16'h8001, 16'hF00F, 16'h1234, 16'hFFFF};
    localparam logic [15:0] V_EXP  [5] = '{16'hA5C3, 16'h8001, 16'h7807, 16'h2468, 16'hFFFF};

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_port();
        cfg_en = 0; cfg_tx_en = 0; cfg_rx_en = 0;
        rx_ready = 1;
        tick_n(1);
        rx_ready = 0;
        tick_n(4);
    endtask

    task automatic start_port(input logic bus, input int sdiv, input logic tl, input logic rl,
                              input logic cont, input logic te, input logic re);
        stop_port();
        cfg_src_bus = bus; cfg_sclk_div = 9'(sdiv); cfg_sync_div = 9'd31;
        cfg_tx_late = tl; cfg_rx_late = rl; cfg_cont = cont;
        tick_n(2);
        cfg_en = 1; cfg_tx_en = te; cfg_rx_en = re;
        tick_n(1);
    endtask

    task automatic wait_rise(output int n);
        logic prev;
        n = 0;
        prev = pcm_sclk;
        while (n < 5000) begin
            @(negedge clk);
            n++;
            if (!prev && pcm_sclk) break;
            prev = pcm_sclk;
        end
    endtask

    task automatic count_rises(input int cycles, output int r);
        logic prev;
        r = 0;
        prev = pcm_sclk;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!prev && pcm_sclk) r++;
            prev = pcm_sclk;
        end
    endtask

    task automatic wait_rx(output logic got);
        got = 0;
        for (int i = 0; i < 3000 && !got; i++) begin
            @(negedge clk);
            got = rx_valid;
        end
    endtask

    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            cnt = (cnt == 2) ? 0 : cnt + 1;
            aud_tick = (cnt == 2);
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 190000 && !done) begin
                n_run++; n_fail++;
                $display("FAIL watchdog: actual %0d expected below 190000", cyc);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int  p, r, hi, per, bad;
        logic got, prev_sdo, prev_sclk;
        tick_n(4);
        rst = 0;
        tick_n(1);
        // R11 reset state
        check({pcm_sclk, pcm_fsync, pcm_sdo, tx_ready, tx_starve, rx_valid} == 6'b0, "R11",
              {pcm_sclk, pcm_fsync, pcm_sdo, tx_ready, tx_starve, rx_valid}, 0);

        // R4 R5 loopback table across MSB positions
        for (int v = 0; v < 5; v++) begin
            tx_data = V_WORD[v]; tx_valid = 1;
            start_port(1, 1, V_LATE[v][1], V_LATE[v][0], 0, 1, 1);
            wait_rx(got);
            check(got && rx_data == V_EXP[v], "R4/R5 loopback", rx_data, V_EXP[v]);
        end

        // R5 word held without rx_ready
        tick_n(200);
        check(rx_valid == 1'b1 && rx_data == 16'hFFFF, "R5 hold", {rx_valid, rx_data}, 17'h1FFFF);

        // R1 bus source: 2*(1+1) cycles per bit
        wait_rise(p); wait_rise(p);
        check(p == 4, "R1 bus period", p, 4);

        // R2 fsync width and frame length
        while (pcm_fsync) @(negedge clk);
        while (!pcm_fsync) @(negedge clk);
        hi = 0;
        while (pcm_fsync) begin @(negedge clk); hi++; end
        check(hi == 4, "R2 fsync width", hi, 4);
        per = hi;
        while (!pcm_fsync) begin @(negedge clk); per++; end
        check(per == 128, "R2 frame length", per, 128);

        // R3 sdo moves only on a sclk rise
        bad = 0;
        tx_data = 16'h5A5A;
        prev_sdo = pcm_sdo; prev_sclk = pcm_sclk;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (pcm_sdo != prev_sdo && !(!prev_sclk && pcm_sclk)) bad++;
            prev_sdo = pcm_sdo; prev_sclk = pcm_sclk;
        end
        check(bad == 0, "R3 sdo edge", bad, 0);

        // R6 one ready per frame
        while (pcm_fsync) @(negedge clk);
        while (!pcm_fsync) @(negedge clk);
        r = 0;
        for (int i = 0; i < 128; i++) begin @(negedge clk); if (tx_ready) r++; end
        check(r == 1, "R6 ready count", r, 1);

        // R10 divider change while running is ignored
        cfg_sclk_div = 9'd7;
        tick_n(10);
        wait_rise(p); wait_rise(p);
        check(p == 4, "R10 frozen divider", p, 4);

        // R1 audio tick source: tick every 3 cycles, div 0 -> 6 cycles
        start_port(0, 0, 0, 0, 0, 1, 1);
        wait_rise(p); wait_rise(p);
        check(p == 6, "R1 audio period", p, 6);

        // R7 starve: zeros and one pulse per frame
        tx_valid = 0;
        start_port(1, 1, 0, 0, 0, 1, 1);
        while (!pcm_fsync) @(negedge clk);
        r = 0;
        for (int i = 0; i < 128; i++) begin @(negedge clk); if (tx_starve) r++; end
        check(r == 1, "R7 starve count", r, 1);
        wait_rx(got);
        check(got && rx_data == 16'h0000, "R7 zero word", rx_data, 0);

        // R8 global enable held by an active direction
        tx_valid = 1;
        start_port(1, 1, 0, 0, 0, 1, 0);
        tick_n(10);
        cfg_en = 0;
        tick_n(3);
        count_rises(40, r);
        check(r > 0, "R8 held running", r, 10);
        cfg_tx_en = 0;
        tick_n(3);
        count_rises(40, r);
        check(r == 0, "R8 stopped", r, 0);

        // R9 gating
        start_port(1, 1, 0, 0, 0, 0, 0);
        count_rises(40, r);
        check(r == 0, "R9 gated idle", r, 0);
        start_port(1, 1, 0, 0, 1, 0, 0);
        count_rises(40, r);
        check(r == 10, "R9 continuous", r, 10);
        cfg_sclk_en = 0;
        tick_n(2);
        count_rises(40, r);
        check(r == 0 && pcm_sclk == 0, "R9 clock gate off", r, 0);
        cfg_sclk_en = 1;
        stop_port();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule